// File: doc/BRIEF.md
# Switch Power-Off Readiness Aggregator

This block sits inside a switch and runs the power-removal readiness sequence for one upstream port and a configurable number of downstream ports. When the turn-off broadcast arrives from upstream, it is forwarded to every enabled downstream port. The block then waits until each downstream port has returned its acknowledge, and answers upstream with a single acknowledge of its own.

Readiness is collected from the bottom up. The block does not begin asking upstream to enter the ready-for-power-off state until every enabled downstream link reports that state. Once it starts, it repeats the enter-L23 request at a fixed spacing until upstream replies. It then emits one electrical-idle ordered set and holds its transmitter in electrical idle. A power-remove permit is raised only after a minimum hold time has passed, counted in clock cycles, with the block idle and all downstream links ready.

Ports can be masked off. A disabled port counts as already acknowledged and already ready. Message encodings and the physical layer are handled elsewhere: every message appears here as a one-cycle pulse.

Top module: `pwroff_ready_agg`

## Requirements
- R1: While `rst_n` is low, all outputs are 0. Reset also clears every recorded downstream acknowledge, so acknowledges received before a reset do not count toward a later sequence.
- R2: A turn-off pulse on `up_turnoff_i` that is sampled while the block is idle drives `dn_turnoff_o` equal to `port_en_i` for exactly one cycle. That cycle is the one following the sampling edge. A turn-off pulse sampled at any other time is ignored.
- R3: Downstream acknowledges are kept in a sticky per-port record, and a repeated acknowledge from the same port has no effect. `up_ack_o` pulses for one cycle. That cycle is the second cycle after the edge that samples the last outstanding acknowledge.
- R4: A port whose `port_en_i` bit is 0 is treated as already acknowledged and already ready, and it receives no turn-off pulse.
- R5: No enter-L23 request is sent before the upstream acknowledge. After the acknowledge, the first request appears in the cycle following the first edge at which every enabled `dn_ready_i` bit is 1.
- R6: The enter-L23 request pulse repeats every RESEND_GAP cycles until `up_l23_reply_i` is sampled.
- R7: The cycle after the edge that samples the reply, `up_eios_o` pulses once. From the following cycle, `up_elec_idle_o` stays 1 until reset.
- R8: `pwr_remove_ok_o` rises only after HOLD_CYCLES = ceil(MIN_HOLD_NS / CLK_NS) consecutive edges with the block in electrical idle and every enabled port ready. If any enabled ready bit drops, the permit falls and the count restarts.
- R9: At most one of the turn-off, upstream acknowledge, enter-L23 request and ordered-set outputs is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en_i | input | N_DN | Per-port enable mask (1 = port takes part) |
| up_turnoff_i | input | 1 | Turn-off broadcast received from upstream (pulse) |
| dn_turnoff_o | output | N_DN | Turn-off forwarded to each downstream port (pulse) |
| dn_ack_i | input | N_DN | Acknowledge received from each downstream port (pulse) |
| up_ack_o | output | 1 | Aggregated acknowledge sent upstream (pulse) |
| dn_ready_i | input | N_DN | Downstream link is in the ready-for-power-off state (level) |
| up_l23_req_o | output | 1 | Enter-L23 request sent upstream (pulse) |
| up_l23_reply_i | input | 1 | Acknowledge reply to the request (pulse) |
| up_eios_o | output | 1 | Send electrical-idle ordered set (pulse) |
| up_elec_idle_o | output | 1 | Upstream transmitter in electrical idle (level) |
| pwr_remove_ok_o | output | 1 | Permit to remove power (level) |

## Verification
The hardest state to reach from the ports is a downstream ready bit dropping inside the hold window. To get there, the whole sequence has to run first: the broadcast, every acknowledge, the ready wait, the request repetitions, the reply and the ordered set. Each directed task drives that sequence in order and counts the cycles. It then pulls one ready bit low once the permit is up, and checks that the permit falls and only comes back after a full new hold window. Separate tasks feed duplicate acknowledges, masked ports and a reset in the middle of collection. These confirm that stale or repeated acknowledges never release the upstream acknowledge early.

// File: rtl/pra_pkg.sv
package pra_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FWD,
    ST_COLLECT,
    ST_SEND_ACK,
    ST_WAIT_RDY,
    ST_REQ,
    ST_SEND_EIOS,
    ST_EIDLE
  } pra_state_e;

  // Smallest whole number of clock cycles covering a delay in ns (at least 1).
  function automatic int hold_cycles(input int delay_ns, input int clk_ns);
    int c;
    c = (delay_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/pra_ack_tracker.sv
module pra_ack_tracker #(
  parameter int N_DN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            acc_en,
  input  logic [N_DN-1:0] ack_i,
  output logic [N_DN-1:0] ack_vec_o
);

  for (genvar p = 0; p < N_DN; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ack_vec_o[p] <= 1'b0;
      else if (clr)               ack_vec_o[p] <= 1'b0;
      else if (acc_en && ack_i[p]) ack_vec_o[p] <= 1'b1;
    end
  end

endmodule

// File: rtl/pra_resend_timer.sv
module pra_resend_timer #(
  parameter int GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic fire_o
);

  localparam int W = (GAP > 1) ? $clog2(GAP) : 1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!active)      cnt_q <= '0;
    else if (cnt_q == '0)  cnt_q <= W'(GAP - 1);
    else                   cnt_q <= cnt_q - 1'b1;
  end

  assign fire_o = active && (cnt_q == '0);

endmodule

// File: rtl/pra_hold_timer.sv
module pra_hold_timer #(
  parameter int HOLD = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic permit_o
);

  localparam int W = $clog2(HOLD + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!arm)              cnt_q <= '0;
    else if (cnt_q != W'(HOLD)) cnt_q <= cnt_q + 1'b1;
  end

  assign permit_o = (cnt_q == W'(HOLD));

endmodule

// File: rtl/pwroff_ready_agg.sv
module pwroff_ready_agg
  import pra_pkg::*;
#(
  parameter int N_DN        = 4,
  parameter int RESEND_GAP  = 4,
  parameter int CLK_NS      = 10,
  parameter int MIN_HOLD_NS = 100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_DN-1:0] port_en_i,
  input  logic            up_turnoff_i,
  output logic [N_DN-1:0] dn_turnoff_o,
  input  logic [N_DN-1:0] dn_ack_i,
  output logic            up_ack_o,
  input  logic [N_DN-1:0] dn_ready_i,
  output logic            up_l23_req_o,
  input  logic            up_l23_reply_i,
  output logic            up_eios_o,
  output logic            up_elec_idle_o,
  output logic            pwr_remove_ok_o
);

  localparam int HOLD_CYCLES = hold_cycles(MIN_HOLD_NS, CLK_NS);

  // A port is settled if its bit is set or it is masked off.
  function automatic logic all_settled(input logic [N_DN-1:0] v,
                                       input logic [N_DN-1:0] en);
    return &(v | ~en);
  endfunction

  pra_state_e state_q, state_d;

  logic [N_DN-1:0] ack_vec;
  logic            all_acked;
  logic            all_ready;
  logic            req_phase;
  logic            hold_arm;
  logic            req_fire;

  assign all_acked = all_settled(ack_vec, port_en_i);
  assign all_ready = all_settled(dn_ready_i, port_en_i);
  assign req_phase = (state_q == ST_REQ);
  assign hold_arm  = (state_q == ST_EIDLE) && all_ready;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (up_turnoff_i)   state_d = ST_FWD;
      ST_FWD:                           state_d = ST_COLLECT;
      ST_COLLECT:   if (all_acked)      state_d = ST_SEND_ACK;
      ST_SEND_ACK:                      state_d = ST_WAIT_RDY;
      ST_WAIT_RDY:  if (all_ready)      state_d = ST_REQ;
      ST_REQ:       if (up_l23_reply_i) state_d = ST_SEND_EIOS;
      ST_SEND_EIOS:                     state_d = ST_EIDLE;
      ST_EIDLE:                         state_d = ST_EIDLE;
      default:                          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  pra_ack_tracker #(.N_DN(N_DN)) i_ack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (state_q == ST_IDLE),
    .acc_en    ((state_q == ST_FWD) || (state_q == ST_COLLECT)),
    .ack_i     (dn_ack_i),
    .ack_vec_o (ack_vec)
  );

  pra_resend_timer #(.GAP(RESEND_GAP)) i_resend (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (req_phase),
    .fire_o (req_fire)
  );

  pra_hold_timer #(.HOLD(HOLD_CYCLES)) i_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (hold_arm),
    .permit_o (pwr_remove_ok_o)
  );

  assign dn_turnoff_o   = (state_q == ST_FWD) ? port_en_i : '0;
  assign up_ack_o       = (state_q == ST_SEND_ACK);
  assign up_l23_req_o   = req_fire;
  assign up_eios_o      = (state_q == ST_SEND_EIOS);
  assign up_elec_idle_o = (state_q == ST_EIDLE);

endmodule

// File: rtl/pra_checker.sv
module pra_checker #(
  parameter int N_DN        = 4,
  parameter int HOLD_CYCLES = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_DN-1:0] port_en_i,
  input logic            up_turnoff_i,
  input logic [N_DN-1:0] dn_turnoff_o,
  input logic [N_DN-1:0] dn_ready_i,
  input logic            up_ack_o,
  input logic            up_l23_req_o,
  input logic            up_l23_reply_i,
  input logic            up_eios_o,
  input logic            up_elec_idle_o,
  input logic            pwr_remove_ok_o,
  input logic [N_DN-1:0] ack_vec,
  input logic            req_phase
);

  int chk_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_run <= 0;
    else if (up_elec_idle_o && (&(dn_ready_i | ~port_en_i))) begin
      if (chk_run < HOLD_CYCLES) chk_run <= chk_run + 1;
    end else chk_run <= 0;
  end

  a_r2_fwd_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_turnoff_o & ~port_en_i) == '0);

  a_r2_fwd_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|dn_turnoff_o) |-> $past(up_turnoff_i));

  a_r3_ack_complete: assert property (@(posedge clk) disable iff (!rst_n)
    up_ack_o |-> (&(ack_vec | ~port_en_i)));

  a_r5_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_phase) |-> $past(&(dn_ready_i | ~port_en_i)));

  a_r5_req_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
    up_l23_req_o |-> req_phase);

  a_r7_eios_cause: assert property (@(posedge clk) disable iff (!rst_n)
    up_eios_o |-> $past(up_l23_reply_i));

  a_r7_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_elec_idle_o) |-> $past(up_eios_o));

  a_r8_permit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_remove_ok_o |-> up_elec_idle_o);

  a_r8_permit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_remove_ok_o |-> (chk_run >= HOLD_CYCLES));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|dn_turnoff_o, up_ack_o, up_l23_req_o, up_eios_o}));

endmodule

bind pwroff_ready_agg pra_checker #(.N_DN(N_DN), .HOLD_CYCLES(HOLD_CYCLES)) i_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .port_en_i       (port_en_i),
  .up_turnoff_i    (up_turnoff_i),
  .dn_turnoff_o    (dn_turnoff_o),
  .dn_ready_i      (dn_ready_i),
  .up_ack_o        (up_ack_o),
  .up_l23_req_o    (up_l23_req_o),
  .up_l23_reply_i  (up_l23_reply_i),
  .up_eios_o       (up_eios_o),
  .up_elec_idle_o  (up_elec_idle_o),
  .pwr_remove_ok_o (pwr_remove_ok_o),
  .ack_vec         (ack_vec),
  .req_phase       (req_phase)
);

// File: tb/test_pwroff_ready_agg.sv
module test_pwroff_ready_agg;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 4;
  localparam int GAP        = 4;
  localparam int HOLD       = 10;  // ceil(100 ns / 10 ns)

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] port_en_i = '1;
  logic         up_turnoff_i = 1'b0;
  logic [N-1:0] dn_turnoff_o;
  logic [N-1:0] dn_ack_i = '0;
  logic         up_ack_o;
  logic [N-1:0] dn_ready_i = '0;
  logic         up_l23_req_o;
  logic         up_l23_reply_i = 1'b0;
  logic         up_eios_o;
  logic         up_elec_idle_o;
  logic         pwr_remove_ok_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwroff_ready_agg #(.N_DN(N), .RESEND_GAP(GAP), .CLK_NS(CLK_PERIOD), .MIN_HOLD_NS(100))
    i_pwroff_ready_agg (
    .clk(clk), .rst_n(rst_n), .port_en_i(port_en_i),
    .up_turnoff_i(up_turnoff_i), .dn_turnoff_o(dn_turnoff_o),
    .dn_ack_i(dn_ack_i), .up_ack_o(up_ack_o), .dn_ready_i(dn_ready_i),
    .up_l23_req_o(up_l23_req_o), .up_l23_reply_i(up_l23_reply_i),
    .up_eios_o(up_eios_o), .up_elec_idle_o(up_elec_idle_o),
    .pwr_remove_ok_o(pwr_remove_ok_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    up_turnoff_i = 1'b0; dn_ack_i = '0; up_l23_reply_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_turnoff();
    up_turnoff_i = 1'b1;
    @(negedge clk);
    up_turnoff_i = 1'b0;
  endtask

  task automatic pulse_ack(input int idx);
    dn_ack_i[idx] = 1'b1;
    @(negedge clk);
    dn_ack_i = '0;
  endtask

  task automatic pulse_reply();
    up_l23_reply_i = 1'b1;
    @(negedge clk);
    up_l23_reply_i = 1'b0;
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 outputs in reset",
        {dn_turnoff_o, up_ack_o, up_l23_req_o, up_eios_o, up_elec_idle_o, pwr_remove_ok_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset",
        {dn_turnoff_o, up_ack_o, up_l23_req_o, up_eios_o, up_elec_idle_o, pwr_remove_ok_o}, '0);
  endtask

  task automatic t_full_sequence();
    int nreq;
    do_reset();
    port_en_i = '1; dn_ready_i = '0;
    pulse_turnoff();
    chk("R2 forward pulse", dn_turnoff_o, 4'b1111);
    @(negedge clk);
    chk("R2 forward one cycle", dn_turnoff_o, 4'b0000);
    pulse_turnoff();
    chk("R2 busy turnoff ignored", dn_turnoff_o, 4'b0000);
    pulse_ack(0); pulse_ack(0); pulse_ack(1); pulse_ack(2); pulse_ack(1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R3 no early upstream ack (duplicates)", up_ack_o, 1'b0);
    end
    pulse_ack(3);
    @(negedge clk);
    chk("R3 upstream ack pulse", up_ack_o, 1'b1);
    @(negedge clk);
    chk("R3 upstream ack single", up_ack_o, 1'b0);
    dn_ready_i = 4'b0111;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R5 no request before all ready", up_l23_req_o, 1'b0);
    end
    dn_ready_i = 4'b1111;
    @(negedge clk);
    chk("R5 first request", up_l23_req_o, 1'b1);
    nreq = 0;
    for (int k = 1; k <= 3 * GAP; k++) begin
      @(negedge clk);
      if (up_l23_req_o) begin
        nreq++;
        chk("R9 request exclusive", {up_ack_o, up_eios_o, |dn_turnoff_o}, 3'b000);
        chk("R6 request spacing", k % GAP, 0);
      end
    end
    chk("R6 request repeats", nreq, 3);
    pulse_reply();
    chk("R7 eios pulse", up_eios_o, 1'b1);
    chk("R7 not yet idle", up_elec_idle_o, 1'b0);
    @(negedge clk);
    chk("R7 eios single", up_eios_o, 1'b0);
    chk("R7 electrical idle", up_elec_idle_o, 1'b1);
    for (int k = 1; k < HOLD; k++) begin
      @(negedge clk);
      chk("R8 permit held off", pwr_remove_ok_o, 1'b0);
    end
    @(negedge clk);
    chk("R8 permit after hold", pwr_remove_ok_o, 1'b1);
    dn_ready_i = 4'b1011;
    @(negedge clk);
    chk("R8 permit drops on ready loss", pwr_remove_ok_o, 1'b0);
    dn_ready_i = 4'b1111;
    for (int k = 1; k < HOLD; k++) begin
      @(negedge clk);
      chk("R8 hold restarts", pwr_remove_ok_o, 1'b0);
    end
    @(negedge clk);
    chk("R8 permit after restart", pwr_remove_ok_o, 1'b1);
    chk("R7 idle stays", up_elec_idle_o, 1'b1);
  endtask

  task automatic t_masked_ports();
    do_reset();
    port_en_i = 4'b0101; dn_ready_i = '0;
    pulse_turnoff();
    chk("R4 forward only to enabled", dn_turnoff_o, 4'b0101);
    pulse_ack(0);
    pulse_ack(2);
    @(negedge clk);
    chk("R4 disabled ports count as acked", up_ack_o, 1'b1);
    dn_ready_i = 4'b0101;
    @(negedge clk);
    @(negedge clk);
    chk("R4 disabled ports count as ready", up_l23_req_o, 1'b1);
    pulse_reply();
    chk("R7 eios masked case", up_eios_o, 1'b1);
    @(negedge clk);
    for (int k = 1; k < HOLD; k++) @(negedge clk);
    @(negedge clk);
    chk("R4 permit with masked ports", pwr_remove_ok_o, 1'b1);
    port_en_i = '1;
  endtask

  task automatic t_reset_mid();
    do_reset();
    port_en_i = '1; dn_ready_i = '0;
    pulse_turnoff();
    pulse_ack(0); pulse_ack(1); pulse_ack(2);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-sequence reset outputs", {dn_turnoff_o, up_ack_o, up_l23_req_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    pulse_turnoff();
    chk("R1 fresh forward after reset", dn_turnoff_o, 4'b1111);
    pulse_ack(3);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R1 old acks cleared", up_ack_o, 1'b0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_full_sequence();
    t_masked_ports();
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule